// File: doc/BRIEF.md
# Micro-op Cache Mode Controller

This block decides, every cycle, how the processor front end supplies micro-ops. It runs in one of three modes. In the filter mode the normal instruction fetch and decode path works alone. In the build mode, basic blocks seen by the small branch predictor are requested for allocation into the micro-op cache. In the fetch mode, micro-ops come only from that cache, and the instruction cache and decoder are switched off.

Movement between the modes follows two edge counters and a build timer. Every predictor lookup carries a "built" bit. A clear bit is counted as a build edge and, in build mode, raises an allocation request for that block. A set bit is counted as a fetch edge. When the micro-op cache reports a tag hit on a requested block, the controller asks the predictor to set that block's built bit, so no tag check is needed when predicting. The controller enters the fetch mode when fetch edges outnumber build edges by a power-of-two ratio before the build timer runs out. It leaves the fetch mode when build edges grow back to a second, separate ratio. Each ratio test is a comparison against a counter shifted left by a constant, so no divider is needed.

Top module: `uopc_mode_ctrl`

## Requirements
- R1: The mode output is encoded 0 = filter, 1 = build, 2 = fetch. After reset the mode is filter and the timer and both edge counters are zero.
- R2: In filter mode, with no flush, a high `seg_ok` moves the mode to build at the next clock edge.
- R3: In build mode, each cycle with `lkp_vld` high adds one to the build timer. If `lkp_built` is also low, the build-edge count grows by one and `alloc_req` is high in that same cycle, with `alloc_id` equal to `lkp_id`. `alloc_req` is low outside build mode.
- R4: In build and fetch modes, each cycle with `lkp_vld` and `lkp_built` high adds one to the fetch-edge count. In build and fetch modes, each cycle with `lkp_vld` high and `lkp_built` low adds one to the build-edge count.
- R5: In build or fetch mode, `hit_vld` raises `bset_req` in the same cycle, with `bset_id` equal to `hit_id`. `bset_req` is low in filter mode. In build mode, a lookup with the built bit clear whose `lkp_id` equals a same-cycle `hit_id` raises no allocation request. That lookup still counts as a build edge.
- R6: In build mode, the mode becomes fetch at the next edge when the registered counts satisfy fetch >= FMIN and fetch >= build * 2^F_SH. This test has priority over the timeout.
- R7: In build mode, if R6 does not apply and the registered timer is at least TMO, the mode returns to filter at the next edge.
- R8: In fetch mode, the mode returns to filter at the next edge when the registered counts satisfy build >= XMIN and build * 2^X_SH >= fetch.
- R9: `icache_en` and `dec_en` are low exactly in fetch mode. `btb_en` is low only in fetch mode while `pred_ok` is high.
- R10: A high `flush` forces the mode to filter at the next edge. A flush takes priority over every other transition.
- R11: The timer and both edge counters read zero in the first cycle of any newly entered mode, and after a flush. The lookup made in the cycle of a transition is not counted. The counters saturate at 2^CW-1, and the timer saturates at TMO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Flush or mispredict: force filter mode |
| seg_ok | input | 1 | Current code segment is predictable and small enough to fit |
| lkp_vld | input | 1 | A small-predictor lookup occurs this cycle |
| lkp_built | input | 1 | Built bit of the looked-up basic block |
| lkp_id | input | IDW | Identifier of the looked-up basic block |
| hit_vld | input | 1 | Micro-op cache tag hit on a requested block |
| hit_id | input | IDW | Identifier of the block that hit |
| pred_ok | input | 1 | Small-predictor predictions are currently accurate |
| mode | output | 2 | Current mode (0 filter, 1 build, 2 fetch) |
| alloc_req | output | 1 | Request to allocate the looked-up block |
| alloc_id | output | IDW | Block identifier for the allocation |
| bset_req | output | 1 | Request to set a block's built bit |
| bset_id | output | IDW | Block whose built bit is to be set |
| icache_en | output | 1 | Instruction cache enable |
| dec_en | output | 1 | Decoder enable |
| btb_en | output | 1 | Main branch target buffer enable |

## Verification
Several behaviours are checked by assertions on every cycle. The cache and decoder enables are low in fetch mode. A flush lands in filter mode. Filter mode never jumps straight to fetch. Allocation happens only in build mode, for unbuilt lookups. The counters are clear on every mode entry, and the timer never passes its limit. The ratio thresholds, the timeout, the priority of entering fetch over a timeout, the dropping of duplicate allocations and the exact counting rules are only shown by the bench's scenarios. In those scenarios a behavioural model tracks the mode and the counts over long runs, with the share of built lookups biased in different ways.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
  typedef enum logic [1:0] {
    MD_FILTER = 2'd0,
    MD_BUILD  = 2'd1,
    MD_FETCH  = 2'd2
  } uopc_mode_e;
endpackage

// File: rtl/uopc_tally.sv
// Saturating up-counter with synchronous clear, used for the timer and edge counts.
module uopc_tally #(
  parameter int W = 8,
  parameter logic [W-1:0] LIMIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != LIMIT));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_tally_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/uopc_ratio.sv
// Shift-and-compare ratio tests for entering and leaving cache-only fetch.
module uopc_ratio #(
  parameter int CW    = 8,
  parameter int UP_SH = 2,
  parameter int UP_MIN = 8,
  parameter int DN_SH = 3,
  parameter int DN_MIN = 2
) (
  input  logic [CW-1:0] bld_cnt,
  input  logic [CW-1:0] fch_cnt,
  output logic          go_fetch,
  output logic          go_filter
);
  localparam int UW = CW + UP_SH;
  localparam int DW = CW + DN_SH;

  logic [UW-1:0] bld_up, fch_up;
  logic [DW-1:0] bld_dn, fch_dn;

  always_comb begin
    bld_up    = UW'(bld_cnt) << UP_SH;
    fch_up    = UW'(fch_cnt);
    bld_dn    = DW'(bld_cnt) << DN_SH;
    fch_dn    = DW'(fch_cnt);
    go_fetch  = (fch_up >= UW'(UP_MIN)) && (fch_up >= bld_up);
    go_filter = (DW'(bld_cnt) >= DW'(DN_MIN)) && (bld_dn >= fch_dn);
  end
endmodule

// File: rtl/uopc_mode_ctrl.sv
module uopc_mode_ctrl
  import uopc_pkg::*;
#(
  parameter int IDW  = 6,
  parameter int CW   = 8,
  parameter int TMO  = 64,
  parameter int F_SH = 2,
  parameter int FMIN = 8,
  parameter int X_SH = 3,
  parameter int XMIN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           seg_ok,
  input  logic           lkp_vld,
  input  logic           lkp_built,
  input  logic [IDW-1:0] lkp_id,
  input  logic           hit_vld,
  input  logic [IDW-1:0] hit_id,
  input  logic           pred_ok,
  output logic [1:0]     mode,
  output logic           alloc_req,
  output logic [IDW-1:0] alloc_id,
  output logic           bset_req,
  output logic [IDW-1:0] bset_id,
  output logic           icache_en,
  output logic           dec_en,
  output logic           btb_en
);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [TW-1:0] TLIM = TW'(TMO);
  localparam logic [CW-1:0] CLIM = '1;

  uopc_mode_e mode_q, mode_d;
  logic [TW-1:0] tmr;
  logic [CW-1:0] bld_cnt, fch_cnt;
  logic go_fetch, go_filter, clr, cnt_on, dup_hit;

  uopc_ratio #(.CW(CW), .UP_SH(F_SH), .UP_MIN(FMIN), .DN_SH(X_SH), .DN_MIN(XMIN)) u_ratio (
    .bld_cnt(bld_cnt), .fch_cnt(fch_cnt), .go_fetch(go_fetch), .go_filter(go_filter));

  always_comb begin
    mode_d = mode_q;
    if (flush) mode_d = MD_FILTER;
    else begin
      case (mode_q)
        MD_FILTER: if (seg_ok) mode_d = MD_BUILD;
        MD_BUILD: begin
          if (go_fetch)          mode_d = MD_FETCH;
          else if (tmr >= TLIM)  mode_d = MD_FILTER;
        end
        MD_FETCH:  if (go_filter) mode_d = MD_FILTER;
        default:   mode_d = MD_FILTER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_FILTER;
    else        mode_q <= mode_d;
  end

  always_comb begin
    clr     = flush || (mode_d != mode_q);
    cnt_on  = lkp_vld && !clr && (mode_q != MD_FILTER);
    dup_hit = hit_vld && (hit_id == lkp_id);
  end

  uopc_tally #(.W(TW), .LIMIT(TLIM)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cnt_on && (mode_q == MD_BUILD)), .cnt(tmr));
  uopc_tally #(.W(CW), .LIMIT(CLIM)) u_bld (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cnt_on && !lkp_built), .cnt(bld_cnt));
  uopc_tally #(.W(CW), .LIMIT(CLIM)) u_fch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cnt_on && lkp_built), .cnt(fch_cnt));

  assign mode      = mode_q;
  assign alloc_req = (mode_q == MD_BUILD) && lkp_vld && !lkp_built && !dup_hit;
  assign alloc_id  = lkp_id;
  assign bset_req  = hit_vld && (mode_q != MD_FILTER);
  assign bset_id   = hit_id;
  assign icache_en = (mode_q != MD_FETCH);
  assign dec_en    = (mode_q != MD_FETCH);
  assign btb_en    = (mode_q != MD_FETCH) || !pred_ok;

  assert_fetch_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!icache_en && !dec_en));
  assert_flush_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mode == 2'd0));
  assert_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode != 2'd2));
  assert_alloc_build_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> ((mode == 2'd1) && !lkp_built && lkp_vld));
  assert_clear_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != mode_d) |=> (tmr == '0 && bld_cnt == '0 && fch_cnt == '0));
endmodule

// File: tb/sim_uopc_mode_ctrl.sv
module sim_uopc_mode_ctrl;
  localparam int IDW = 6, TMO = 64, F_SH = 2, FMIN = 8, X_SH = 3, XMIN = 2, CMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, seg_ok = 0, lkp_vld = 0, lkp_built = 0, hit_vld = 0, pred_ok = 0;
  logic [IDW-1:0] lkp_id = '0, hit_id = '0;
  logic [1:0] mode;
  logic alloc_req, bset_req, icache_en, dec_en, btb_en;
  logic [IDW-1:0] alloc_id, bset_id;

  int checks = 0, fails = 0, cyc = 0;
  int m = 0, t = 0, b = 0, f = 0;

  always #10 clk = ~clk;

  uopc_mode_ctrl u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .seg_ok(seg_ok),
    .lkp_vld(lkp_vld), .lkp_built(lkp_built), .lkp_id(lkp_id), .hit_vld(hit_vld),
    .hit_id(hit_id), .pred_ok(pred_ok), .mode(mode), .alloc_req(alloc_req),
    .alloc_id(alloc_id), .bset_req(bset_req), .bset_id(bset_id),
    .icache_en(icache_en), .dec_en(dec_en), .btb_en(btb_en));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit ea, eb;
    ea = (m == 1) && lkp_vld && !lkp_built && !(hit_vld && hit_id == lkp_id);
    eb = hit_vld && (m != 0);
    chk(mode == 2'(m), "R1/R2/R6/R7/R8/R10 mode", mode, m);
    chk(alloc_req == ea, "R3/R5 alloc_req", alloc_req, ea);
    if (ea) chk(alloc_id == lkp_id, "R3 alloc_id", alloc_id, lkp_id);
    chk(bset_req == eb, "R5 bset_req", bset_req, eb);
    if (eb) chk(bset_id == hit_id, "R5 bset_id", bset_id, hit_id);
    chk(icache_en == (m != 2) && dec_en == (m != 2), "R9 icache/dec", icache_en, m != 2);
    chk(btb_en == ((m != 2) || !pred_ok), "R9 btb_en", btb_en, (m != 2) || !pred_ok);
  endtask

  // Behavioural model step (R4, R6, R7, R8, R10, R11)
  task automatic step();
    int nm;
    nm = m;
    if (flush) nm = 0;
    else if (m == 0) begin if (seg_ok) nm = 1; end
    else if (m == 1) begin
      if (f >= FMIN && f >= (b << F_SH)) nm = 2;
      else if (t >= TMO) nm = 0;
    end else begin
      if (b >= XMIN && (b << X_SH) >= f) nm = 0;
    end
    if (flush || nm != m) begin t = 0; b = 0; f = 0; end
    else if (m != 0 && lkp_vld) begin
      if (m == 1 && t < TMO) t++;
      if (lkp_built) begin if (f < CMAX) f++; end
      else if (b < CMAX) b++;
    end
    m = nm;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(mode == 2'd0, "R1 reset mode", mode, 0);
    chk(icache_en && dec_en && btb_en, "R1 reset enables", icache_en, 1);
    rst_n = 1'b1;
    for (int rep = 0; rep < 3; rep++) begin
      for (int ph = 0; ph < 5; ph++) begin
        for (int k = 0; k < 700; k++) begin
          int pb, pf, ps;
          @(negedge clk);
          cyc++;
          case (ph)
            0: begin pb = 92; pf = 0; ps = 30; end
            1: begin pb = 15; pf = 0; ps = 30; end
            2: begin pb = 55; pf = 0; ps = 40; end
            3: begin pb = 80; pf = 4; ps = 50; end
            default: begin pb = 97; pf = 1; ps = 60; end
          endcase
          flush     = ($urandom % 100) < pf;
          seg_ok    = ($urandom % 100) < ps;
          lkp_vld   = ($urandom % 100) < 85;
          lkp_built = ($urandom % 100) < pb;
          lkp_id    = IDW'($urandom);
          hit_vld   = ($urandom % 100) < 25;
          hit_id    = (($urandom % 3) == 0) ? lkp_id : IDW'($urandom);
          pred_ok   = ($urandom % 100) < 70;
          #1;
          compare();
          @(posedge clk);
          step();
        end
      end
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule